// File: doc/BRIEF.md
# Chip-Select Region Decoder

This block compares every bus address against eight programmable address regions and drives one active-low select line for the region that claims it. Each region is described by a pair of 32-bit registers: a region register that gives the start address, the valid, write-protect and parity flags, the port width and the timing machine that serves the region, and a mask register that gives the address mask, the burst-inhibit and row/column multiplex flags, and eight timing option bits for the simple machine. On a hit, the block reports the winning region's machine code, port width, burst-inhibit, multiplex and parity flags to the timing engines downstream. The decode is combinational within the access cycle.

Region 0 serves the boot memory. It leaves reset already valid, and its start address and port width come from a boot configuration word sampled during reset. Its machine code is always the simple machine, and its timing option bits are fixed. A write that falls in a write-protected region gets no select line. It raises an error strobe and sets a per-region sticky flag in a status word, and software clears that flag by writing a one to it.

Top module: `csdec`

## Requirements
- R1: With `bus_valid` high, region i matches when its valid bit (region register bit 0) is 1 and `(bus_addr[31:16] ^ region[31:16]) & mask[31:16]` is zero. For the winning region, `cs_n[i]` is 0 and `hit` is 1. With `bus_valid` low, all `cs_n` bits are 1.
- R2: A region whose valid bit is 0 never asserts its select line, whatever its address and mask hold.
- R3: When several regions match, the lowest-numbered one wins. At most one `cs_n` bit is low at any time.
- R4: On a hit, the outputs carry the winning region's fields. `sel_mach` comes from region bits [7:6] (00 simple, 10 machine A, 11 machine B). `sel_ps` comes from region bits [11:10] (00 32-bit, 01 8-bit, 10 16-bit). `sel_par` comes from region bit 9. `sel_bih` comes from mask bit 8, where 0 allows bursts. `sel_amux` comes from mask bit 9. With no hit, all of these outputs are 0.
- R5: After reset, region 0 reads `{boot_cfg[17:2], 4'h0, boot_cfg[1:0], 9'h0, 1'b1}` and its mask register reads `{BOOT_MASK, 8'h00, BOOT_TIM}`. All other region and mask registers read 0, and the status word reads 0.
- R6: Region 0's mask bits [7:0] always read `BOOT_TIM`, and its region bits [7:6] always read 00, whatever value is written to them.
- R7: A write access (`bus_write` = 1) that would hit a region whose write-protect bit (region bit 8) is 1 asserts no select line. It drives `hit` to 0 and `wp_err` to 1 in that same cycle.
- R8: A write-protect violation sets status bit i (status word bits [7:0]) on the next clock edge for the offending region i. Writing a 1 to a status bit clears it, and a set in the same cycle takes priority over the clear.
- R9: Register map on `reg_addr`. Bit 4 = 1 selects the status word. Otherwise bits [3:1] give the region, and bit 0 selects the region register (0) or the mask register (1). `reg_rdata` returns the selected register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_cfg | input | 18 | Boot word sampled during reset: [17:2] region 0 start, [1:0] port width |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| bus_valid | input | 1 | Access in progress |
| bus_write | input | 1 | 1 for a write access |
| bus_addr | input | 32 | Access address |
| cs_n | output | 8 | Active-low select lines |
| hit | output | 1 | A select line is asserted |
| sel_mach | output | 2 | Timing machine of winning region |
| sel_ps | output | 2 | Port width of winning region |
| sel_par | output | 1 | Parity enable of winning region |
| sel_bih | output | 1 | Burst inhibit of winning region |
| sel_amux | output | 1 | Address multiplex enable of winning region |
| wp_err | output | 1 | Write blocked by protection |

## Verification
The hardest situation to reach is a write-protected region that overlaps a lower-numbered region, because only the winner's protect bit may block the access. Region start addresses are drawn from a pool of four values, and masks are drawn from four coarse values, so overlaps between regions happen often. Protect bits and valid bits are randomised alongside them, and a reference model predicts which region wins. Directed cases add a set coinciding with a write-one clear, and attempts to overwrite the boot region's fixed fields.

// File: rtl/csdec.sv
module csdec #(
  parameter int NREG = 8,
  parameter int AW = 32,
  parameter logic [15:0] BOOT_MASK = 16'hFF00,
  parameter logic [7:0] BOOT_TIM = 8'hF5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [17:0]     boot_cfg,
  input  logic            reg_we,
  input  logic [4:0]      reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  input  logic            bus_valid,
  input  logic            bus_write,
  input  logic [AW-1:0]   bus_addr,
  output logic [NREG-1:0] cs_n,
  output logic            hit,
  output logic [1:0]      sel_mach,
  output logic [1:0]      sel_ps,
  output logic            sel_par,
  output logic            sel_bih,
  output logic            sel_amux,
  output logic            wp_err
);
  localparam int RW = $clog2(NREG);

  logic [31:0] rgn_q [NREG];
  logic [31:0] msk_q [NREG];
  logic [NREG-1:0] stat_q;
  logic [NREG-1:0] match;
  logic [RW-1:0] win;
  logic found, blocked, go;
  logic [RW-1:0] ridx;

  assign ridx = reg_addr[RW:1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        rgn_q[i] <= '0;
        msk_q[i] <= '0;
      end
      rgn_q[0] <= {boot_cfg[17:2], 4'h0, boot_cfg[1:0], 9'h0, 1'b1};
      msk_q[0] <= {BOOT_MASK, 8'h00, BOOT_TIM};
      stat_q <= '0;
    end else begin
      if (reg_we && !reg_addr[4]) begin
        if (!reg_addr[0])
          rgn_q[ridx] <= (ridx == 0) ? {reg_wdata[31:8], 2'b00, reg_wdata[5:0]} : reg_wdata;
        else
          msk_q[ridx] <= (ridx == 0) ? {reg_wdata[31:8], BOOT_TIM} : reg_wdata;
      end
      for (int i = 0; i < NREG; i++) begin
        if (blocked && win == RW'(i))
          stat_q[i] <= 1'b1;
        else if (reg_we && reg_addr[4] && reg_wdata[i])
          stat_q[i] <= 1'b0;
      end
    end
  end

  always_comb begin
    if (reg_addr[4]) reg_rdata = 32'(stat_q);
    else if (reg_addr[0]) reg_rdata = msk_q[ridx];
    else reg_rdata = rgn_q[ridx];
  end

  always_comb begin
    for (int i = 0; i < NREG; i++)
      match[i] = rgn_q[i][0] &&
                 (((bus_addr[AW-1:AW-16] ^ rgn_q[i][31:16]) & msk_q[i][31:16]) == 16'h0);
  end

  always_comb begin
    win = '0;
    found = 1'b0;
    for (int i = NREG - 1; i >= 0; i--)
      if (match[i]) begin
        win = RW'(i);
        found = 1'b1;
      end
  end

  assign blocked = bus_valid && found && bus_write && rgn_q[win][8];
  assign go = bus_valid && found && !blocked;
  assign wp_err = blocked;
  assign hit = go;

  always_comb begin
    cs_n = '1;
    if (go) cs_n[win] = 1'b0;
  end

  assign sel_mach = go ? rgn_q[win][7:6] : 2'b00;
  assign sel_ps   = go ? rgn_q[win][11:10] : 2'b00;
  assign sel_par  = go & rgn_q[win][9];
  assign sel_bih  = go & msk_q[win][8];
  assign sel_amux = go & msk_q[win][9];

  p_one_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));
  p_cs_needs_hit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n != '1) |-> (hit && bus_valid));
  p_wp_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wp_err |-> (cs_n == '1 && !hit && bus_write));
  p_wp_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wp_err |=> (stat_q != '0));
  p_boot_fixed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (msk_q[0][7:0] == BOOT_TIM) && (rgn_q[0][7:6] == 2'b00));
  p_idle_fields_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (sel_mach == 2'b00 && sel_ps == 2'b00 && !sel_bih && !sel_amux && !sel_par));

  generate
    for (genvar g = 0; g < NREG; g++) begin : g_chk
      p_valid_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n[g] |-> rgn_q[g][0]);
    end
  endgenerate
endmodule

// File: tb/sim_csdec.sv
module sim_csdec;
  localparam int CLK = 10;
  localparam logic [15:0] BMASK = 16'hFF00;
  localparam logic [7:0] BTIM = 8'hF5;

  logic clk = 0, rst_n = 0;
  logic [17:0] boot_cfg = {16'h1280, 2'b01};
  logic reg_we = 0;
  logic [4:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic bus_valid = 0, bus_write = 0;
  logic [31:0] bus_addr = 0;
  logic [7:0] cs_n;
  logic hit, sel_par, sel_bih, sel_amux, wp_err;
  logic [1:0] sel_mach, sel_ps;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] mb [8];
  logic [31:0] mo [8];
  logic [7:0] mst;

  csdec u0 (.clk, .rst_n, .boot_cfg, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
    .bus_valid, .bus_write, .bus_addr, .cs_n, .hit, .sel_mach, .sel_ps,
    .sel_par, .sel_bih, .sel_amux, .wp_err);

  always #(CLK/2) clk = ~clk;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void mwrite(logic [4:0] a, logic [31:0] d);
    if (a[4]) mst = mst & ~d[7:0];
    else if (!a[0]) mb[a[3:1]] = (a[3:1] == 0) ? {d[31:8], 2'b00, d[5:0]} : d;
    else mo[a[3:1]] = (a[3:1] == 0) ? {d[31:8], BTIM} : d;
  endfunction

  function automatic logic [31:0] mread(logic [4:0] a);
    if (a[4]) return {24'h0, mst};
    return a[0] ? mo[a[3:1]] : mb[a[3:1]];
  endfunction

  // packed expectation {wp, hit, cs_n, mach, ps, par, bih, amux}; also returns winner
  function automatic logic [63:0] mdecode(logic v, logic w, logic [31:0] ad, output int wi);
    logic [7:0] c = 8'hFF;
    logic go = 0, wp = 0;
    logic [1:0] ma = 0, ps = 0;
    logic pa = 0, bi = 0, am = 0;
    wi = -1;
    for (int i = 7; i >= 0; i--)
      if (mb[i][0] && (((ad[31:16] ^ mb[i][31:16]) & mo[i][31:16]) == 0)) wi = i;
    if (v && wi >= 0) begin
      if (w && mb[wi][8]) wp = 1;
      else begin
        go = 1; c[wi] = 0; ma = mb[wi][7:6]; ps = mb[wi][11:10];
        pa = mb[wi][9]; bi = mo[wi][8]; am = mo[wi][9];
      end
    end
    return {47'h0, wp, go, c, ma, ps, pa, bi, am};
  endfunction

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    mwrite(a, d);
    #1 reg_we = 0;
  endtask

  task automatic rd(string req, logic [4:0] a);
    @(negedge clk);
    reg_addr = a;
    #1 chk(req, reg_rdata, mread(a));
  endtask

  task automatic acc(string req, logic w, logic [31:0] ad);
    int wi;
    logic [63:0] e;
    @(negedge clk);
    bus_valid = 1; bus_write = w; bus_addr = ad;
    e = mdecode(1, w, ad, wi);
    #1 chk(req, {47'h0, wp_err, hit, cs_n, sel_mach, sel_ps, sel_par, sel_bih, sel_amux}, e);
    @(posedge clk);
    if (e[16]) mst[wi] = 1'b1;
    #1 bus_valid = 0;
  endtask

  function automatic logic [15:0] pick_hi();
    logic [15:0] t [4] = '{16'h1280, 16'h1200, 16'h0000, 16'h12FF};
    logic [15:0] h = t[$urandom % 4];
    if ($urandom % 2) h[7:0] = 8'($urandom);
    return h;
  endfunction

  initial begin
    #(CLK * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7));
    for (int i = 0; i < 8; i++) begin mb[i] = 0; mo[i] = 0; end
    mb[0] = {16'h1280, 4'h0, 2'b01, 9'h0, 1'b1};
    mo[0] = {BMASK, 8'h00, BTIM};
    mst = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R5 reset state
    for (int a = 0; a < 16; a++) rd("R5", 5'(a));
    rd("R5", 5'h10);
    chk("R1", {56'h0, cs_n}, 64'hFF);
    acc("R5", 0, 32'h1280_1234);
    // R1 base/mask compare; R9 map
    wr(5'd2, {16'h4000, 4'h0, 2'b10, 1'b1, 1'b0, 2'b10, 5'h0, 1'b1});
    wr(5'd3, {16'hFFF0, 6'h0, 1'b1, 1'b1, 8'h33});
    rd("R9", 5'd2); rd("R9", 5'd3);
    acc("R1", 0, 32'h4003_0000);
    acc("R4", 1, 32'h4007_0000);
    acc("R1", 0, 32'h4010_0000);
    // R2 invalid region ignored
    wr(5'd4, {16'h5000, 15'h0, 1'b0});
    wr(5'd5, 32'hFFFF_0000);
    acc("R2", 0, 32'h5000_0000);
    // R3 overlap: region 3 covers region 1 space, lowest wins
    wr(5'd6, {16'h4000, 15'h0, 1'b1});
    wr(5'd7, 32'hFF00_0000);
    acc("R3", 0, 32'h4000_8000);
    // R6 region 0 fixed fields
    wr(5'd0, 32'h1280_04C1);
    wr(5'd1, 32'hFF00_03AA);
    rd("R6", 5'd0); rd("R6", 5'd1);
    acc("R6", 0, 32'h1280_0000);
    // R7 protected write blocked, R8 sticky + W1C
    wr(5'd2, {16'h4000, 7'h0, 1'b1, 7'h0, 1'b1});
    acc("R7", 1, 32'h4000_0010);
    acc("R7", 0, 32'h4000_0010);
    rd("R8", 5'h10);
    wr(5'h10, 32'h0000_0001);
    rd("R8", 5'h10);
    wr(5'h10, 32'h0000_0002);
    rd("R8", 5'h10);
    // R8 set wins over simultaneous clear
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = 32'h4000_0020;
    reg_we = 1; reg_addr = 5'h10; reg_wdata = 32'h2;
    @(posedge clk);
    mst[1] = 1'b1;
    #1 begin bus_valid = 0; reg_we = 0; end
    rd("R8", 5'h10);

    // constrained random
    for (int n = 0; n < 60; n++) begin
      int r = $urandom % 8;
      if ($urandom % 2)
        wr(5'(r * 2), {pick_hi(), 4'h0, 2'($urandom % 3), 1'($urandom), 1'(($urandom % 4) == 0),
                       ($urandom % 3 == 0) ? 2'b00 : (($urandom % 2) ? 2'b10 : 2'b11),
                       5'h0, 1'(($urandom % 5) != 0)});
      else begin
        logic [15:0] mt [4] = '{16'hFFFF, 16'hFF00, 16'hFE00, 16'hF000};
        wr(5'(r * 2 + 1), {mt[$urandom % 4], 6'h0, 1'($urandom), 1'($urandom), 8'($urandom)});
      end
      for (int k = 0; k < 8; k++) acc("R1", 1'($urandom), {pick_hi(), 16'($urandom)});
      rd("R8", 5'h10);
      if ($urandom % 4 == 0) wr(5'h10, 32'($urandom % 256));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule